// File: doc/BRIEF.md
# Systolic Multiprecision Integer Multiplier

This block multiplies two long unsigned integers, A and B, each stored as an array of machine words with the least significant word at index 0. It returns the lowest `len_p` words of the product. A fixed row of `LANES` processing elements does the work. Each element performs a word-sized multiply-accumulate with a carry. B is divided into chunks of `LANES` words. During one pass, every chunk goes through the row once, one chunk per clock cycle, while the current word of A is held on all elements. The block makes one pass for each product word.

Software first fills two local operand stores through simple write ports. It then pulses `start` together with the operand length `len_ab` and the product length `len_p`. Each element keeps a private accumulator word and a private carry word for every chunk. At the end of each pass the accumulator moves down by one word position, which carries partial sums across chunk boundaries. Because of this, a short row handles any operand length up to `MAX_WORDS`. The block presents each finished product word once, with `p_valid` and its index. It raises `done` on the last word.

Top module: `mpmul_systolic`

## Requirements
- R1: After a start is accepted, exactly `len_p` words appear on `p_word` with `p_valid` high. Their `p_index` values run 0, 1, …, `len_p`−1 in order, one word per pass. `p_valid` is never high while `busy` is low.
- R2: Product word i equals bits [i·W+W−1 : i·W] of A×B, where A and B are the first `len_ab` stored words with index 0 least significant. This holds for every `len_ab` from 1 to `MAX_WORDS`, including lengths that are not multiples of `LANES`.
- R3: Stored operand words at index `len_ab` and above have no effect on the result. Every product word with index 2·`len_ab` or more is zero.
- R4: A pass lasts ceil(`len_ab`/`LANES`) cycles. Two successive `p_valid` cycles of one run are exactly that many cycles apart.
- R5: `done` is high for exactly one cycle, in the same cycle as the `p_valid` of word `len_p`−1. `busy` is high from the cycle after start is accepted through that cycle, and low in the cycle after it.
- R6: `start` is sampled only while `busy` is low. A start pulse during a run, with different lengths, does not change that run's words or its word count.
- R7: Each accepted start clears every accumulator and carry word. A run's result does not depend on any earlier run.
- R8: While reset is asserted, `busy`, `done` and `p_valid` are low.
- R9: Results stay exact when carries are at their largest, which happens when every operand word is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_we | input | 1 | Write strobe for the A operand store |
| a_waddr | input | clog2(MAX_WORDS) | Word index of the A write |
| a_wdata | input | WORD_W | A word to store |
| b_we | input | 1 | Write strobe for the B operand store |
| b_waddr | input | clog2(MAX_WORDS) | Word index of the B write |
| b_wdata | input | WORD_W | B word to store |
| start | input | 1 | Begin a multiplication (sampled while idle) |
| len_ab | input | clog2(MAX_WORDS+1) | Operand length in words, 1..MAX_WORDS |
| len_p | input | clog2(2·MAX_WORDS+1) | Product length in words, 1..2·MAX_WORDS |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse with the final product word |
| p_valid | output | 1 | `p_word` and `p_index` carry a finished product word |
| p_index | output | clog2(2·MAX_WORDS+1) | Index of the presented product word |
| p_word | output | WORD_W | Product word |

## Verification
The assertions assume that start is only accepted with `len_ab` between 1 and `MAX_WORDS` and `len_p` between 1 and twice `MAX_WORDS`. They also assume that the operand stores are not written while a run is in progress. The stimulus meets both assumptions: it sweeps every legal operand length on a reduced configuration, with product lengths at 1, at the operand length and around twice the operand length, and it performs all store writes while the block is idle. Only the extra start pulse deliberately lands during a run, carrying different but still legal lengths.

// File: rtl/mpmul_pkg.sv
package mpmul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_FINISH = 2'd2
  } mp_state_e;

endpackage

// File: rtl/mpmul_wordbank.sv
// Small register-file word store: one clocked write port, one combinational read port.
module mpmul_wordbank #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(raddr) < DEPTH) begin
      rdata = mem[raddr];
    end
  end

endmodule

// File: rtl/mpmul_pe.sv
// One processing element: word multiply-accumulate, plus a private
// accumulator word and carry word for every chunk.
module mpmul_pe #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4,
  parameter int CW     = 2
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              en,
  input  logic [CW-1:0]     chunk,
  input  logic [WORD_W-1:0] a_word,
  input  logic [WORD_W-1:0] b_word,
  input  logic              t_we,
  input  logic [CW-1:0]     t_waddr,
  input  logic [WORD_W-1:0] t_wdata,
  output logic [WORD_W-1:0] sum,
  output logic [WORD_W-1:0] carry
);

  localparam int DW = 2 * WORD_W;

  logic [WORD_W-1:0] t_mem [DEPTH];
  logic [WORD_W-1:0] c_mem [DEPTH];
  logic [WORD_W-1:0] t_rd;
  logic [WORD_W-1:0] c_rd;
  logic [DW-1:0]     mac;

  always_comb begin
    t_rd = t_mem[chunk];
    c_rd = c_mem[chunk];
    // the largest possible result, (2^W-1)^2 + 2(2^W-1), still fits in 2W bits
    mac  = DW'(a_word) * DW'(b_word) + DW'(t_rd) + DW'(c_rd);
    sum   = mac[WORD_W-1:0];
    carry = mac[DW-1:WORD_W];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int e = 0; e < DEPTH; e++) begin
        t_mem[e] <= '0;
        c_mem[e] <= '0;
      end
    end else begin
      if (en) begin
        c_mem[chunk] <= carry;
      end
      if (t_we) begin
        t_mem[t_waddr] <= t_wdata;
      end
    end
  end

endmodule

// File: rtl/mpmul_seq.sv
// Sequencer: takes the lengths, walks chunk and pass counters, presents product words.
module mpmul_seq
  import mpmul_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int LANES      = 8,
  parameter int MAX_WORDS  = 32,
  parameter int MAX_CHUNKS = 4,
  parameter int CW         = 2,
  parameter int LW         = 6,
  parameter int PW         = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LW-1:0]     len_ab,
  input  logic [PW-1:0]     len_p,
  input  logic [WORD_W-1:0] s0,
  output logic              busy,
  output logic              done,
  output logic              p_valid,
  output logic [PW-1:0]     p_index,
  output logic [WORD_W-1:0] p_word,
  output logic              run,
  output logic              clr,
  output logic [CW-1:0]     chunk,
  output logic [PW-1:0]     pass,
  output logic [LW-1:0]     lab
);

  localparam int NB  = $clog2(LANES);
  localparam int NCW = $clog2(MAX_CHUNKS + 1);

  mp_state_e         state_q, state_d;
  logic [LW-1:0]     lab_q, lab_d;
  logic [PW-1:0]     lp_q, lp_d;
  logic [NCW-1:0]    nch_q, nch_d;
  logic [PW-1:0]     i_q, i_d;
  logic [CW-1:0]     k_q, k_d;
  logic              pv_q, pv_d;
  logic [PW-1:0]     pidx_q, pidx_d;
  logic [WORD_W-1:0] pw_q, pw_d;
  logic              last_chunk;

  assign last_chunk = (NCW'(k_q) + NCW'(1)) == nch_q;

  // next-state process
  always_comb begin
    state_d = state_q;
    lab_d   = lab_q;
    lp_d    = lp_q;
    nch_d   = nch_q;
    i_d     = i_q;
    k_d     = k_q;
    pv_d    = 1'b0;
    pidx_d  = pidx_q;
    pw_d    = pw_q;
    run     = 1'b0;
    clr     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          clr     = 1'b1;
          lab_d   = len_ab;
          lp_d    = len_p;
          nch_d   = NCW'(({1'b0, len_ab} + (LW+1)'(LANES - 1)) >> NB);
          i_d     = '0;
          k_d     = '0;
          state_d = (len_p == '0) ? ST_FINISH : ST_RUN;
        end
      end
      ST_RUN: begin
        run = 1'b1;
        if (k_q == '0) begin
          pv_d   = 1'b1;
          pidx_d = i_q;
          pw_d   = s0;
          if (i_q == lp_q - PW'(1)) begin
            state_d = ST_FINISH;
          end
        end
        if (last_chunk) begin
          k_d = '0;
          i_d = i_q + PW'(1);
        end else begin
          k_d = k_q + CW'(1);
        end
      end
      ST_FINISH: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lab_q   <= '0;
      lp_q    <= '0;
      nch_q   <= '0;
      i_q     <= '0;
      k_q     <= '0;
      pv_q    <= 1'b0;
      pidx_q  <= '0;
      pw_q    <= '0;
    end else begin
      state_q <= state_d;
      lab_q   <= lab_d;
      lp_q    <= lp_d;
      nch_q   <= nch_d;
      i_q     <= i_d;
      k_q     <= k_d;
      pv_q    <= pv_d;
      pidx_q  <= pidx_d;
      pw_q    <= pw_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_FINISH);
  assign p_valid = pv_q;
  assign p_index = pidx_q;
  assign p_word  = pw_q;
  assign chunk   = k_q;
  assign pass    = i_q;
  assign lab     = lab_q;

  // checking support: words presented so far and cycles since the last one
  logic [PW-1:0]  chk_cnt_q;
  logic [NCW:0]   chk_gap_q;
  logic           chk_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_cnt_q  <= '0;
      chk_gap_q  <= '0;
      chk_seen_q <= 1'b0;
    end else if (clr) begin
      chk_cnt_q  <= '0;
      chk_gap_q  <= '0;
      chk_seen_q <= 1'b0;
    end else begin
      if (pv_q) begin
        chk_cnt_q  <= chk_cnt_q + PW'(1);
        chk_gap_q  <= (NCW+1)'(1);
        chk_seen_q <= 1'b1;
      end else if (chk_gap_q != '1) begin
        chk_gap_q  <= chk_gap_q + (NCW+1)'(1);
      end
    end
  end

  AST_INDEX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid |-> (p_index == chk_cnt_q)); // R1
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !p_valid); // R1
  AST_PASS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && chk_seen_q) |-> (chk_gap_q == (NCW+1)'(nch_q))); // R4
  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (p_valid && (p_index == lp_q - PW'(1)))); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |-> ((len_ab != '0) && (int'(len_ab) <= MAX_WORDS) &&
                          (len_p != '0) && (int'(len_p) <= 2 * MAX_WORDS))); // R6

endmodule

// File: rtl/mpmul_systolic.sv
module mpmul_systolic
  import mpmul_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int LANES     = 8,   // power of two, at least 2
  parameter int MAX_WORDS = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               a_we,
  input  logic [$clog2(MAX_WORDS)-1:0]       a_waddr,
  input  logic [WORD_W-1:0]                  a_wdata,
  input  logic                               b_we,
  input  logic [$clog2(MAX_WORDS)-1:0]       b_waddr,
  input  logic [WORD_W-1:0]                  b_wdata,
  input  logic                               start,
  input  logic [$clog2(MAX_WORDS+1)-1:0]     len_ab,
  input  logic [$clog2(2*MAX_WORDS+1)-1:0]   len_p,
  output logic                               busy,
  output logic                               done,
  output logic                               p_valid,
  output logic [$clog2(2*MAX_WORDS+1)-1:0]   p_index,
  output logic [WORD_W-1:0]                  p_word
);

  localparam int MAX_CHUNKS = (MAX_WORDS + LANES - 1) / LANES;
  localparam int CW   = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1;
  localparam int AW   = $clog2(MAX_WORDS);
  localparam int LW   = $clog2(MAX_WORDS + 1);
  localparam int PW   = $clog2(2 * MAX_WORDS + 1);
  localparam int NB   = $clog2(LANES);
  localparam int BIW  = CW + NB;
  localparam int CMPW = (BIW > LW) ? BIW : LW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic              run;
  logic              clr;
  logic [CW-1:0]     chunk;
  logic [PW-1:0]     pass;
  logic [LW-1:0]     lab;
  logic [WORD_W-1:0] a_rd;
  logic [WORD_W-1:0] a_live;
  logic [WORD_W-1:0] b_rd   [LANES];
  logic [WORD_W-1:0] b_live [LANES];
  logic [WORD_W-1:0] s      [LANES];
  logic [WORD_W-1:0] cy     [LANES];

  // A store: one word per pass, zero past the operand length
  mpmul_wordbank #(.WORD_W(WORD_W), .DEPTH(MAX_WORDS), .ADDR_W(AW)) u_abank (
    .clk   (clk),
    .we    (a_we),
    .waddr (a_waddr),
    .wdata (a_wdata),
    .raddr (AW'(pass)),
    .rdata (a_rd)
  );

  assign a_live = (pass < PW'(lab)) ? a_rd : '0;

  generate
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      localparam logic [NB-1:0] LANE_ID = NB'(j);

      logic          bank_we;
      logic [CW-1:0] bank_row;
      logic          in_range;

      // B word n lives in bank n mod LANES, row n / LANES
      assign bank_we  = b_we && (b_waddr[NB-1:0] == LANE_ID);
      assign bank_row = CW'(b_waddr >> NB);

      mpmul_wordbank #(.WORD_W(WORD_W), .DEPTH(MAX_CHUNKS), .ADDR_W(CW)) u_bbank (
        .clk   (clk),
        .we    (bank_we),
        .waddr (bank_row),
        .wdata (b_wdata),
        .raddr (chunk),
        .rdata (b_rd[j])
      );

      assign in_range  = CMPW'({chunk, LANE_ID}) < CMPW'(lab);
      assign b_live[j] = in_range ? b_rd[j] : '0;

      logic              t_we;
      logic [CW-1:0]     t_waddr;
      logic [WORD_W-1:0] t_wdata;

      if (j < LANES - 1) begin : g_inner
        // the accumulator moves down one lane inside the chunk
        assign t_we    = run;
        assign t_waddr = chunk;
        assign t_wdata = s[j+1];
      end else begin : g_edge
        // the top lane of the previous chunk takes lane 0 of this chunk
        assign t_we    = run && (chunk != '0);
        assign t_waddr = chunk - CW'(1);
        assign t_wdata = s[0];
      end

      mpmul_pe #(.WORD_W(WORD_W), .DEPTH(MAX_CHUNKS), .CW(CW)) u_pe (
        .clk     (clk),
        .clr     (clr),
        .en      (run),
        .chunk   (chunk),
        .a_word  (a_live),
        .b_word  (b_live[j]),
        .t_we    (t_we),
        .t_waddr (t_waddr),
        .t_wdata (t_wdata),
        .sum     (s[j]),
        .carry   (cy[j])
      );
    end
  endgenerate

  mpmul_seq #(
    .WORD_W     (WORD_W),
    .LANES      (LANES),
    .MAX_WORDS  (MAX_WORDS),
    .MAX_CHUNKS (MAX_CHUNKS),
    .CW         (CW),
    .LW         (LW),
    .PW         (PW)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (start),
    .len_ab  (len_ab),
    .len_p   (len_p),
    .s0      (s[0]),
    .busy    (busy),
    .done    (done),
    .p_valid (p_valid),
    .p_index (p_index),
    .p_word  (p_word),
    .run     (run),
    .clr     (clr),
    .chunk   (chunk),
    .pass    (pass),
    .lab     (lab)
  );

  AST_ZERO_A_PAST_LEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (run && (pass >= PW'(lab))) |-> (a_live == '0)); // R3
  AST_NO_RUN_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    run |-> busy); // R1

endmodule

// File: tb/test_mpmul_systolic.sv
module test_mpmul_systolic;

  localparam int TW   = 16;
  localparam int TN   = 4;
  localparam int MAXL = 10;
  localparam int AW   = $clog2(MAXL);
  localparam int LW   = $clog2(MAXL + 1);
  localparam int PW   = $clog2(2 * MAXL + 1);
  localparam longint unsigned WMASK = (64'd1 << TW) - 1;

  logic          clk;
  logic          rst_n;
  logic          a_we, b_we;
  logic [AW-1:0] a_waddr, b_waddr;
  logic [TW-1:0] a_wdata, b_wdata;
  logic          start;
  logic [LW-1:0] len_ab;
  logic [PW-1:0] len_p;
  logic          busy, done, p_valid;
  logic [PW-1:0] p_index;
  logic [TW-1:0] p_word;

  mpmul_systolic #(.WORD_W(TW), .LANES(TN), .MAX_WORDS(MAXL)) i_mpmul_systolic (
    .clk(clk), .rst_n(rst_n),
    .a_we(a_we), .a_waddr(a_waddr), .a_wdata(a_wdata),
    .b_we(b_we), .b_waddr(b_waddr), .b_wdata(b_wdata),
    .start(start), .len_ab(len_ab), .len_p(len_p),
    .busy(busy), .done(done), .p_valid(p_valid),
    .p_index(p_index), .p_word(p_word)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // monitor state
  longint unsigned got [2*MAXL];
  int  got_cnt, cur_lp, cur_nch, cyc, last_cyc;
  bit  mon_on = 0, first_word, done_seen;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      chk(1'b0, "watchdog", cyc, 190000);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
    if (mon_on) begin
      if (p_valid) begin
        chk(int'(p_index) == got_cnt, "R1 index order", p_index, got_cnt);
        if (!first_word) chk(cyc - last_cyc == cur_nch, "R4 pass spacing", cyc - last_cyc, cur_nch);
        first_word = 0;
        last_cyc = cyc;
        if (int'(p_index) < 2 * MAXL) got[p_index] = p_word;
        got_cnt++;
      end
      if (done) begin
        chk(p_valid && int'(p_index) == cur_lp - 1, "R5 done on last word", p_index, cur_lp - 1);
        done_seen = 1;
      end
    end
  end

  longint unsigned av [MAXL];
  longint unsigned bv [MAXL];
  longint unsigned ev [2*MAXL];

  task automatic write_word(input bit to_b, input int idx, input longint unsigned val);
    @(negedge clk);
    if (to_b) begin b_we = 1; b_waddr = AW'(idx); b_wdata = TW'(val); end
    else      begin a_we = 1; a_waddr = AW'(idx); a_wdata = TW'(val); end
    @(negedge clk);
    a_we = 0; b_we = 0;
  endtask

  task automatic do_run(input int lab, input int lp, input int pat, input string tag);
    longint unsigned acc, cy;
    int nch;
    bit poked;
    for (int x = 0; x < MAXL; x++) begin
      if (x < lab) begin
        case (pat)
          0: begin av[x] = $urandom & WMASK; bv[x] = $urandom & WMASK; end
          1: begin av[x] = WMASK; bv[x] = WMASK; end
          default: begin av[x] = (x == lab - 1) ? (64'd1 << (TW - 1)) : 0; bv[x] = $urandom & WMASK; end
        endcase
      end else begin
        av[x] = $urandom & WMASK;  // junk beyond the operand length (R3)
        bv[x] = $urandom & WMASK;
      end
      write_word(0, x, av[x]);
      write_word(1, x, bv[x]);
    end
    for (int x = 0; x < 2 * MAXL; x++) ev[x] = 0;
    for (int x = 0; x < lab; x++) begin
      cy = 0;
      for (int y = 0; y < lab; y++) begin
        acc = ev[x+y] + av[x] * bv[y] + cy;
        ev[x+y] = acc & WMASK;
        cy = acc >> TW;
      end
      ev[x+lab] = cy;
    end
    nch = (lab + TN - 1) / TN;
    cur_lp = lp; cur_nch = nch; got_cnt = 0; first_word = 1; done_seen = 0;
    for (int x = 0; x < 2 * MAXL; x++) got[x] = 0;
    @(negedge clk);
    start = 1; len_ab = LW'(lab); len_p = PW'(lp);
    @(negedge clk);
    start = 0;
    chk(busy, "R5 busy after start", busy, 1);
    poked = 0;
    if ((lp - 1) * nch >= 3) begin
      start = 1; len_ab = LW'(1); len_p = PW'(1);  // R6: must be ignored
      @(negedge clk);
      start = 0;
      poked = 1;
    end
    for (int w = 0; w < 4000 && !done_seen; w++) @(negedge clk);
    chk(done_seen, "R5 done seen", done_seen, 1);
    @(negedge clk);
    chk(!busy && !done, "R5 idle after done", {busy, done}, 0);
    chk(got_cnt == lp, poked ? "R6 count with ignored start" : "R1 word count", got_cnt, lp);
    for (int w = 0; w < lp; w++) begin
      if (w >= 2 * lab) chk(got[w] == 0, "R3 high word zero", got[w], 0);
      else              chk(got[w] == ev[w], tag, got[w], ev[w]);
    end
  endtask

  initial begin
    int lps [5];
    rst_n = 0; start = 0; a_we = 0; b_we = 0;
    a_waddr = '0; b_waddr = '0; a_wdata = '0; b_wdata = '0;
    len_ab = '0; len_p = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !p_valid, "R8 reset outputs", {busy, done, p_valid}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !p_valid, "R8 after release", {busy, done, p_valid}, 0);
    mon_on = 1;
    for (int lab = 1; lab <= MAXL; lab++) begin
      lps[0] = 1; lps[1] = lab; lps[2] = 2 * lab - 1; lps[3] = 2 * lab;
      lps[4] = (2 * lab + 2 <= 2 * MAXL) ? 2 * lab + 2 : 2 * MAXL;
      for (int c = 0; c < 5; c++) begin
        int pat;
        pat = (lab + c) % 3;
        do_run(lab, lps[c], pat, pat == 1 ? "R9 all-ones product" : "R2 product word");
      end
    end
    // R7: large saturated run, then small runs must not see its leftovers
    do_run(MAXL, 2 * MAXL, 1, "R9 all-ones product");
    do_run(1, 4, 0, "R7 fresh state");
    do_run(5, 12, 2, "R7 fresh state");
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule